// File: doc/BRIEF.md
# Branch-Aware Instruction Prefetch Queue

This block keeps a short queue of 16-bit instruction words ahead of the decode stage. It fetches words through a request/acknowledge memory port, and it issues a new fetch only when the shared bus is not claimed for data traffic. The queue holds three words, so one instruction can execute, the next can decode and a third can arrive from memory at the same time. Decode takes words through a valid/ready handshake. Each word is delivered once and in address order.

Decode supplies simple hints. A branch hint carries a target address. While that branch is unresolved, the queue keeps fetching along the fall-through path and also fetches the single word at the target into a separate slot, which has priority on the bus. A one-cycle resolve pulse with a taken bit then selects a path. If the branch is taken and the target word is already present, that word is at the decode port on the next cycle. If the target word has not arrived, the queue flushes and restarts fetching at the target. If the branch is not taken, the target slot is emptied and the fall-through words stay in the queue.

A loop hint freezes a full queue of three words. While frozen, the queue issues no instruction fetches and hands the three words to decode again and again, so the bus carries only data transfers. A loop-end pulse empties the queue, and fetching resumes at the address after the third frozen word.

Top module: `insn_prefetch_queue`

## Requirements
- R1: While reset is asserted, `dec_valid` and `fetch_req` are low. The first fetch after reset uses the address present on `start_addr` during reset, and later sequential fetches step the address by one word.
- R2: Decode receives words in address order, each word exactly once, and a word moves only on a cycle where `dec_valid` and `dec_ready` are both high. No more than three words are held.
- R3: A fetch request is raised only on a clock edge where `data_busy` is low. Once raised, `fetch_req` and `fetch_addr` stay unchanged until the edge that samples `fetch_ack` high.
- R4: A `br_hint` pulse with no branch pending records `br_target`. The word at that address is fetched into a target slot, ahead of any further sequential fetch, while the branch is pending.
- R5: If the branch is resolved taken and the target word is present, or arrives on the same edge as the resolve, that word is at the decode port on the following cycle. Decode then continues at the target plus one.
- R6: If the branch is resolved taken before the target word arrives, the queue is emptied, any fetch in flight is discarded when it completes, and fetching restarts at the target address.
- R7: If the branch is resolved not taken, the target word is discarded and decode continues with the word that follows the branch.
- R8: A `loop_enter` pulse taken while three words are held and no branch is pending starts loop mode. In loop mode there are no fetch requests, and decode receives the three held words in cyclic order for as long as the mode lasts.
- R9: A `loop_exit` pulse in loop mode empties the queue and ends the mode. The next word delivered to decode is the one at the address after the third frozen word.
- R10: A `loop_enter` pulse taken while fewer than three words are held is ignored. Fetching and sequential delivery continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_addr | input | AW | Word address of the first fetch, sampled during reset |
| data_busy | input | 1 | Bus claimed for data transfers this cycle |
| fetch_req | output | 1 | Instruction fetch request, held until acknowledged |
| fetch_addr | output | AW | Word address of the request |
| fetch_ack | input | 1 | Memory returns the word this cycle |
| fetch_data | input | WW | Returned instruction word |
| dec_valid | output | 1 | A word is offered to decode |
| dec_ready | input | 1 | Decode accepts the offered word |
| dec_word | output | WW | Offered instruction word |
| br_hint | input | 1 | Pulse: conditional branch detected |
| br_target | input | AW | Word address of the branch target |
| br_resolve | input | 1 | Pulse: branch condition known |
| br_taken | input | 1 | With `br_resolve`: branch is taken |
| loop_enter | input | 1 | Pulse: short loop detected; freeze and replay |
| loop_exit | input | 1 | Pulse: loop termination reached |

## Verification
The tightest case is a branch resolution that lands on the same edge as the acknowledge of the target fetch. The slot has not yet captured the word, so the queue must take it straight from the memory port. To provoke this, the bench stops its random memory responder and acknowledges fetches itself. It answers the fall-through requests at once and holds back the target request until it can drive the acknowledge and a taken resolve together. It then expects the target word at the decode port on the next cycle, and the following word at target plus one. Random runs cover the other timings of resolve against the target fetch: resolve on the edge after the hint, resolve after the target has arrived, and resolve after random delays, with both taken and not-taken outcomes. Each outcome is compared against a stream of expected addresses.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  // Origin of the word carried by the current fetch request
  typedef enum logic {FK_SEQ = 1'b0, FK_TGT = 1'b1} fetch_kind_e;

  // Circular pointer step for a ring of n entries
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/ipq_word_fifo.sv
module ipq_word_fifo
  import ipq_pkg::*;
#(
  parameter int WW    = 16,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [WW-1:0] push_word,
  input  logic          pop,
  input  logic          loop_arm,
  input  logic          loop_on,
  output logic [WW-1:0] head_word,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WW-1:0] slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, rep_ptr;
  logic [CW-1:0] cnt;

  // Named events: a draining pop frees a slot, a replay step only rotates
  logic pop_drain, replay_step;
  assign pop_drain   = pop && !loop_on && !loop_arm;
  assign replay_step = pop && (loop_on || loop_arm);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return PW'(wrap_inc(32'(p), DEPTH));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      rep_ptr <= '0;
      cnt     <= '0;
    end else if (flush) begin
      rd_ptr  <= '0;
      wr_ptr  <= push ? nxt('0) : '0;
      rep_ptr <= '0;
      cnt     <= push ? CW'(1) : '0;
    end else begin
      if (push)      wr_ptr <= nxt(wr_ptr);
      if (pop_drain) rd_ptr <= nxt(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop_drain);
      if (loop_arm)         rep_ptr <= replay_step ? nxt(rd_ptr) : rd_ptr;
      else if (replay_step) rep_ptr <= nxt(rep_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[flush ? '0 : wr_ptr] <= push_word;
  end

  assign head_word = loop_on ? slots[rep_ptr] : slots[rd_ptr];
  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush && full) |-> pop_drain);
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_drain |-> !empty);
  // R8
  replay_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && !flush) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/ipq_fetch_ctl.sv
module ipq_fetch_ctl
  import ipq_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_busy,
  input  logic          want_tgt,
  input  logic          want_seq,
  input  logic [AW-1:0] seq_addr,
  input  logic [AW-1:0] tgt_addr,
  input  logic          kill,
  input  logic          fetch_ack,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  output fetch_kind_e   req_kind,
  output logic          ack_live,
  output logic          issue_fire
);
  logic stale;

  // A new request starts only with the port idle and the bus free
  assign issue_fire = !fetch_req && !data_busy && (want_tgt || want_seq);
  assign ack_live   = fetch_req && fetch_ack && !stale;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
      req_kind   <= FK_SEQ;
      stale      <= 1'b0;
    end else if (issue_fire) begin
      fetch_req  <= 1'b1;
      fetch_addr <= want_tgt ? tgt_addr : seq_addr;
      req_kind   <= want_tgt ? FK_TGT : FK_SEQ;
      stale      <= 1'b0;
    end else if (fetch_req && fetch_ack) begin
      fetch_req  <= 1'b0;
      stale      <= 1'b0;
    end else if (fetch_req && kill) begin
      stale      <= 1'b1;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));
  // R3
  idle_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> $past(!data_busy));
endmodule

// File: rtl/ipq_branch_slot.sv
module ipq_branch_slot #(
  parameter int AW = 24,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hint,
  input  logic [AW-1:0] target,
  input  logic          resolve_fire,
  input  logic          tgt_ack_live,
  input  logic [WW-1:0] ack_word,
  input  logic          tgt_inflight,
  output logic          pending,
  output logic [AW-1:0] tgt_addr,
  output logic          tgt_valid,
  output logic [WW-1:0] tgt_word,
  output logic          tgt_need
);
  assign tgt_need = pending && !tgt_valid && !tgt_inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      tgt_addr  <= '0;
      tgt_valid <= 1'b0;
      tgt_word  <= '0;
    end else if (resolve_fire) begin
      pending   <= 1'b0;
      tgt_valid <= 1'b0;
    end else if (hint && !pending) begin
      pending   <= 1'b1;
      tgt_addr  <= target;
      tgt_valid <= 1'b0;
    end else if (tgt_ack_live && pending) begin
      tgt_valid <= 1'b1;
      tgt_word  <= ack_word;
    end
  end

  // R4
  tgt_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> pending);
  // R4
  tgt_single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> !tgt_inflight);
endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue
  import ipq_pkg::*;
#(
  parameter int AW    = 24,
  parameter int WW    = 16,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_addr,
  input  logic          data_busy,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic [WW-1:0] fetch_data,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [WW-1:0] dec_word,
  input  logic          br_hint,
  input  logic [AW-1:0] br_target,
  input  logic          br_resolve,
  input  logic          br_taken,
  input  logic          loop_enter,
  input  logic          loop_exit
);
  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] seq_pc, tgt_addr;
  logic [WW-1:0] tgt_word, fifo_head, chosen_word, push_word;
  logic          loop_on, pending, tgt_valid, tgt_need;
  logic          fifo_empty, fifo_full, ack_live, issue_fire;
  fetch_kind_e   req_kind;

  // Named internal events
  logic resolve_fire, taken_fire, loop_arm, loop_exit_fire, redirect;
  logic seq_ack_live, tgt_ack_live, tgt_have_now, kill;
  logic want_seq, want_tgt, flush, push, pop;

  assign resolve_fire   = br_resolve && pending;
  assign taken_fire     = resolve_fire && br_taken;
  assign loop_arm       = loop_enter && !loop_on && !pending && fifo_full;
  assign loop_exit_fire = loop_exit && loop_on;
  assign redirect       = resolve_fire || loop_exit_fire || loop_arm;

  assign seq_ack_live = ack_live && (req_kind == FK_SEQ);
  assign tgt_ack_live = ack_live && (req_kind == FK_TGT);
  assign tgt_have_now = tgt_valid || tgt_ack_live;
  assign chosen_word  = tgt_valid ? tgt_word : fetch_data;

  assign kill = taken_fire || (resolve_fire && !br_taken && req_kind == FK_TGT);

  assign want_tgt = tgt_need && !redirect;
  assign want_seq = !loop_on && !fifo_full && !redirect;

  assign flush     = taken_fire || loop_exit_fire;
  assign push      = taken_fire ? tgt_have_now : (!loop_exit_fire && seq_ack_live);
  assign push_word = taken_fire ? chosen_word : fetch_data;

  assign dec_valid = loop_on || !fifo_empty;
  assign dec_word  = fifo_head;
  assign pop       = dec_valid && dec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_pc  <= start_addr;
      loop_on <= 1'b0;
    end else begin
      if (taken_fire)
        seq_pc <= tgt_have_now ? addr_after(tgt_addr) : tgt_addr;
      else if (issue_fire && !want_tgt)
        seq_pc <= addr_after(seq_pc);
      if (loop_arm)            loop_on <= 1'b1;
      else if (loop_exit_fire) loop_on <= 1'b0;
    end
  end

  ipq_fetch_ctl #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_busy  (data_busy),
    .want_tgt   (want_tgt),
    .want_seq   (want_seq),
    .seq_addr   (seq_pc),
    .tgt_addr   (tgt_addr),
    .kill       (kill),
    .fetch_ack  (fetch_ack),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .req_kind   (req_kind),
    .ack_live   (ack_live),
    .issue_fire (issue_fire)
  );

  ipq_branch_slot #(.AW(AW), .WW(WW)) u_branch (
    .clk          (clk),
    .rst_n        (rst_n),
    .hint         (br_hint),
    .target       (br_target),
    .resolve_fire (resolve_fire),
    .tgt_ack_live (tgt_ack_live),
    .ack_word     (fetch_data),
    .tgt_inflight (fetch_req && req_kind == FK_TGT),
    .pending      (pending),
    .tgt_addr     (tgt_addr),
    .tgt_valid    (tgt_valid),
    .tgt_word     (tgt_word),
    .tgt_need     (tgt_need)
  );

  ipq_word_fifo #(.WW(WW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_word (push_word),
    .pop       (pop),
    .loop_arm  (loop_arm),
    .loop_on   (loop_on),
    .head_word (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  // R8
  loop_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> !fetch_req);
  // R5
  taken_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_fire && tgt_have_now) |=> (dec_valid && dec_word == $past(chosen_word)));
  // R6
  taken_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_fire && !tgt_have_now) |=> !dec_valid);
  // R7
  not_taken_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_fire && !br_taken && dec_valid && !dec_ready) |=> dec_valid);
  // R9
  loop_exit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit_fire |=> !dec_valid);
endmodule

// File: tb/insn_prefetch_queue_tb_top.sv
module insn_prefetch_queue_tb_top;
  localparam int AW = 24;
  localparam int WW = 16;
  localparam logic [AW-1:0] START = 24'h000100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] start_addr = START;
  logic          data_busy = 1'b0;
  logic          fetch_req;
  logic [AW-1:0] fetch_addr;
  logic          fetch_ack = 1'b0;
  logic [WW-1:0] fetch_data = '0;
  logic          dec_valid;
  logic          dec_ready = 1'b0;
  logic [WW-1:0] dec_word;
  logic          br_hint = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic          br_resolve = 1'b0;
  logic          br_taken = 1'b0;
  logic          loop_enter = 1'b0;
  logic          loop_exit = 1'b0;

  insn_prefetch_queue #(.AW(AW), .WW(WW), .DEPTH(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .data_busy(data_busy),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_data(fetch_data), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_word(dec_word), .br_hint(br_hint), .br_target(br_target),
    .br_resolve(br_resolve), .br_taken(br_taken), .loop_enter(loop_enter),
    .loop_exit(loop_exit)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int busy_pct = 30;
  bit resp_pause = 1'b0;
  bit in_loop_tb = 1'b0;
  bit first_seen = 1'b0;
  logic [AW-1:0] first_addr = '0;
  logic [AW-1:0] watch_addr = '1;
  bit watch_hit = 1'b0;
  logic [AW-1:0] exp_pc;
  bit finished = 1'b0;

  // Memory content: a scrambled function of the word address
  function automatic logic [WW-1:0] word_at(input logic [AW-1:0] a);
    logic [WW-1:0] r;
    r = a[15:0] * 16'h9E37;
    r = r ^ {8'hA5, a[23:16]};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bus load
  initial begin
    forever begin
      @(negedge clk);
      data_busy = (($urandom % 100) < busy_pct);
    end
  end

  // Memory responder with random latency
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (resp_pause) begin
      end else if (fetch_ack) begin
        fetch_ack = 1'b0;
      end else if (rst_n && fetch_req) begin
        if (lat == 0) begin
          fetch_ack  = 1'b1;
          fetch_data = word_at(fetch_addr);
          lat = $urandom % 4;
        end else begin
          lat--;
        end
      end
    end
  end

  // Port monitor, sampled just after each rising edge
  initial begin
    bit prev_req = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    forever begin
      @(posedge clk);
      #2;
      if (!rst_n) begin
        prev_req = 1'b0;
      end else begin
        if (fetch_req && !prev_req) begin
          chk(!data_busy, "R3 issue with bus busy", 32'(data_busy), 0);
          if (!first_seen) begin
            first_seen = 1'b1;
            first_addr = fetch_addr;
          end
        end
        if (prev_req && !fetch_ack)
          chk(fetch_req && fetch_addr == prev_addr, "R3 request not held", 32'(fetch_addr), 32'(prev_addr));
        if (prev_req && fetch_ack && prev_addr == watch_addr) watch_hit = 1'b1;
        if (in_loop_tb) chk(!fetch_req, "R8 fetch during loop", 32'(fetch_req), 0);
        prev_req  = fetch_req;
        prev_addr = fetch_addr;
      end
    end
  end

  // Accept one word from decode and compare it with the word at address a
  task automatic take_word(input logic [AW-1:0] a, input string req);
    bit got = 1'b0;
    while (!got) begin
      @(negedge clk);
      if (dec_valid && ($urandom % 4 != 0)) begin
        dec_ready = 1'b1;
        chk(dec_word == word_at(a), req, 32'(dec_word), 32'(word_at(a)));
        @(negedge clk);
        dec_ready = 1'b0;
        got = 1'b1;
      end
    end
  endtask

  task automatic take_seq(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      take_word(exp_pc, req);
      exp_pc = exp_pc + 1;
    end
  endtask

  function automatic logic [AW-1:0] pick_target();
    return {~exp_pc[AW-1], 7'($urandom), 16'($urandom)};
  endfunction

  // mode 0: resolve on the edge after the hint; 1: after target arrives; 2: random delay
  task automatic do_branch(input bit taken, input int mode);
    logic [AW-1:0] t;
    t = pick_target();
    take_seq(1, "R2 branch word");
    watch_addr = t;
    watch_hit  = 1'b0;
    br_hint   = 1'b1;
    br_target = t;
    @(negedge clk);
    br_hint = 1'b0;
    if (mode == 1) begin
      while (!watch_hit) @(negedge clk);
    end else if (mode == 2) begin
      repeat ($urandom % 6) @(negedge clk);
    end
    br_resolve = 1'b1;
    br_taken   = taken;
    @(negedge clk);
    br_resolve = 1'b0;
    br_taken   = 1'b0;
    if (taken && mode == 1)
      chk(dec_valid && dec_word == word_at(t), "R5 target word next cycle", 32'(dec_word), 32'(word_at(t)));
    if (taken) begin
      exp_pc = t;
      take_seq(2, (mode == 0) ? "R6 refetch at target" : "R5 continue at target");
    end else begin
      take_seq(2, "R7 not taken continues");
    end
    watch_addr = '1;
  endtask

  // Resolve lands on the same edge as the target acknowledge
  task automatic coincident_branch();
    logic [AW-1:0] t;
    bit hit = 1'b0;
    t = pick_target();
    take_seq(1, "R2 branch word");
    resp_pause = 1'b1;
    br_hint   = 1'b1;
    br_target = t;
    while (!hit) begin
      @(negedge clk);
      br_hint = 1'b0;
      if (fetch_ack) begin
        fetch_ack = 1'b0;
      end else if (fetch_req) begin
        fetch_ack  = 1'b1;
        fetch_data = word_at(fetch_addr);
        if (fetch_addr == t) begin
          br_resolve = 1'b1;
          br_taken   = 1'b1;
          hit = 1'b1;
        end
      end
    end
    @(negedge clk);
    fetch_ack  = 1'b0;
    br_resolve = 1'b0;
    br_taken   = 1'b0;
    chk(dec_valid && dec_word == word_at(t), "R5 coincident ack and resolve", 32'(dec_word), 32'(word_at(t)));
    resp_pause = 1'b0;
    exp_pc = t;
    take_seq(2, "R5 coincident continue");
  endtask

  task automatic loop_run(input int reps);
    dec_ready = 1'b0;
    repeat (40) @(negedge clk);
    loop_enter = 1'b1;
    @(negedge clk);
    loop_enter = 1'b0;
    in_loop_tb = 1'b1;
    for (int i = 0; i < reps; i++) take_word(exp_pc + AW'(i % 3), "R8 replay order");
    loop_exit = 1'b1;
    @(negedge clk);
    loop_exit  = 1'b0;
    in_loop_tb = 1'b0;
    chk(!dec_valid, "R9 queue empty after loop end", 32'(dec_valid), 0);
    exp_pc = exp_pc + 3;
    take_seq(2, "R9 resume after loop");
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_pc = START;
    repeat (4) @(negedge clk);
    chk(!dec_valid && !fetch_req, "R1 idle in reset", {dec_valid, fetch_req}, 0);
    rst_n = 1'b1;
    // R10: loop request on an empty queue is ignored
    loop_enter = 1'b1;
    @(negedge clk);
    loop_enter = 1'b0;
    take_seq(5, "R10 ignored loop enter");
    chk(first_addr == START, "R1 first fetch address", 32'(first_addr), 32'(START));

    // Directed corners
    do_branch(1'b1, 1);
    do_branch(1'b1, 0);
    do_branch(1'b0, 1);
    coincident_branch();
    loop_run(7);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      case ($urandom % 7)
        0, 1: take_seq(1 + $urandom % 5, "R2 sequential");
        2: do_branch(1'b1, $urandom % 3);
        3: do_branch(1'b0, $urandom % 3);
        4: coincident_branch();
        5: loop_run(3 + $urandom % 6);
        default: begin
          busy_pct = 85;
          take_seq(3, "R3 heavy data traffic");
          busy_pct = 30;
        end
      endcase
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule